// File: doc/BRIEF.md
# SPI Status and Control Register

This block is the status-and-control byte of an SPI peripheral, seen from a simple CPU bus. It keeps the receive-full flag, the overflow and mode-fault error flags and the transmit-empty flag. It also keeps four writable settings: an error interrupt enable, a mode-fault enable and a two-bit baud-rate select. The shift register, baud generator and DMA engine sit outside the block. They report to it through single-cycle event strobes.

A receive-full event goes to one of two places, picked by a DMA-select input that comes from the companion control register. With DMA-select low, the event drives a CPU interrupt line. In that mode the flag clears only after a handshake: a status read that saw the flag set, followed by a data-register read. With DMA-select high, the event drives a DMA service-request line, and any data-register read clears the flag. A CPU data read can therefore take a request away from the DMA engine.

Top module: `spi_stat_ctl`

## Requirements
- R1: After reset the status byte reads 0x08. Only the transmit-empty flag is set, and rx_irq, rx_dma_req and err_irq are all low.
- R2: Status byte layout, bit 7 down to bit 0: receive-full, error-interrupt-enable, overflow, mode-fault, transmit-empty, mode-fault-enable, rate bit 1, rate bit 0. bus_rdata shows this byte while bus_addr equals the status address, and 0 otherwise.
- R3: rx_byte_done sets receive-full at the next clock edge. A bus write cannot set it.
- R4: rx_irq equals receive-full AND rx_irq_en AND NOT dma_sel. rx_dma_req equals receive-full AND rx_irq_en AND dma_sel. Both follow the flag in the same cycle.
- R5: With dma_sel = 0, a data read clears receive-full only if an earlier status read saw the flag at 1. A data read with no such status read leaves the flag set.
- R6: With dma_sel = 1, any data-register read clears receive-full.
- R7: When rx_byte_done arrives in the same cycle as a clearing data read, receive-full stays at 1.
- R8: A status write loads only bit 6 (error-interrupt-enable), bit 2 (mode-fault-enable) and bits 1:0 (rate). Bits 7, 5, 4 and 3 are unaffected.
- R9: err_irq is registered. It rises one cycle after error-interrupt-enable AND (overflow OR mode-fault) becomes true.
- R10: ovr_evt sets the overflow flag. mfault_evt sets the mode-fault flag only while mode-fault-enable is 1.
- R11: A status read that saw overflow or mode-fault set, followed by a data read, clears both error flags. A new event in the clearing cycle keeps its own flag set.
- R12: tx_load_evt clears transmit-empty and tx_xfer_evt sets it. When both arrive in the same cycle, the flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Status byte when the status address is selected |
| rx_irq_en | input | 1 | Receive request enable from the control register |
| dma_sel | input | 1 | Routes receive requests to DMA when 1 |
| rx_byte_done | input | 1 | A received byte entered the receive data register |
| ovr_evt | input | 1 | Receive overflow event |
| mfault_evt | input | 1 | Mode-fault event |
| tx_load_evt | input | 1 | Transmit data register was loaded |
| tx_xfer_evt | input | 1 | Transmit byte moved into the shift register |
| rx_irq | output | 1 | Receive CPU interrupt request |
| rx_dma_req | output | 1 | Receive DMA service request |
| err_irq | output | 1 | Error CPU interrupt request |

## Verification
Every flag, the handshake state and the writable bits change at the clock edge that samples the strobe. The bench therefore updates its model at that edge and compares the status byte one step later, after it has turned the address back to the status register without a read. rx_irq and rx_dma_req are combinational from the flag, so they are checked in that same step. err_irq carries one more register, so its expected value is built from the model's previous-cycle flags. Directed steps cover the same-cycle collisions: a byte arriving during a clearing read, load meeting transfer, and a status write against the flags.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
   localparam int STAT_W = 8;
   localparam int RATE_W = 2;

   // Field order is the visible bit order, bit 7 first.
   typedef struct packed {
      logic              rx_full;
      logic              err_ie;
      logic              ovf;
      logic              mfault;
      logic              tx_empty;
      logic              mf_en;
      logic [RATE_W-1:0] rate;
   } spi_stat_t;
endpackage

// File: rtl/spi_rx_flag.sv
module spi_rx_flag #(
   parameter bit REQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic byte_done,
   input  logic stat_rd,
   input  logic data_rd,
   input  logic dma_sel,
   input  logic rx_ie,
   output logic rx_full,
   output logic rx_irq,
   output logic rx_dma_req
);
   logic armed;
   logic clr_now;

   always_comb clr_now = data_rd && (dma_sel || armed);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_full <= 1'b0;
         armed   <= 1'b0;
      end else begin
         if (byte_done)    rx_full <= 1'b1;
         else if (clr_now) rx_full <= 1'b0;
         if (stat_rd && rx_full) armed <= 1'b1;
         else if (clr_now)       armed <= 1'b0;
      end
   end

   generate
      if (REQ_REG) begin : g_req_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rx_irq     <= 1'b0;
               rx_dma_req <= 1'b0;
            end else begin
               rx_irq     <= rx_full && rx_ie && !dma_sel;
               rx_dma_req <= rx_full && rx_ie && dma_sel;
            end
         end
      end else begin : g_req_comb
         assign rx_irq     = rx_full && rx_ie && !dma_sel;
         assign rx_dma_req = rx_full && rx_ie && dma_sel;
      end
   endgenerate

   assert_rx_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> $past(byte_done));
   assert_rx_clr_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_full) |-> $past(data_rd));
   assert_rx_cpu_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rx_full) && !$past(dma_sel)) |-> $past(armed));
   assert_rx_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_irq && rx_dma_req));
endmodule

// File: rtl/spi_err_flags.sv
module spi_err_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic ovr_evt,
   input  logic mf_evt,
   input  logic mf_en,
   input  logic err_ie,
   input  logic stat_rd,
   input  logic data_rd,
   output logic ovf,
   output logic mfault,
   output logic err_irq
);
   logic earmed;
   logic eclr;

   always_comb eclr = data_rd && earmed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf     <= 1'b0;
         mfault  <= 1'b0;
         earmed  <= 1'b0;
         err_irq <= 1'b0;
      end else begin
         if (ovr_evt)   ovf <= 1'b1;
         else if (eclr) ovf <= 1'b0;
         if (mf_evt && mf_en) mfault <= 1'b1;
         else if (eclr)       mfault <= 1'b0;
         if (stat_rd && (ovf || mfault)) earmed <= 1'b1;
         else if (eclr)                  earmed <= 1'b0;
         err_irq <= err_ie && (ovf || mfault);
      end
   end

   assert_err_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_irq |-> $past(err_ie));
   assert_ovf_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> $past(ovr_evt));
   assert_mf_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mfault) |-> $past(mf_evt && mf_en));
   assert_err_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovf) |-> $past(data_rd && earmed));
endmodule

// File: rtl/spi_ctl_bits.sv
module spi_ctl_bits #(
   parameter int RATE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_ie,
   input  logic              wr_mfen,
   input  logic [RATE_W-1:0] wr_rate,
   input  logic              tx_load,
   input  logic              tx_xfer,
   output logic              err_ie,
   output logic              mf_en,
   output logic [RATE_W-1:0] rate,
   output logic              tx_empty
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_ie   <= 1'b0;
         mf_en    <= 1'b0;
         rate     <= '0;
         tx_empty <= 1'b1;
      end else begin
         if (wr_en) begin
            err_ie <= wr_ie;
            mf_en  <= wr_mfen;
            rate   <= wr_rate;
         end
         if (tx_load)      tx_empty <= 1'b0;
         else if (tx_xfer) tx_empty <= 1'b1;
      end
   end

   assert_tx_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |=> !tx_empty);
   assert_tx_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_empty) |-> $past(tx_xfer));
endmodule

// File: rtl/spi_stat_ctl.sv
module spi_stat_ctl #(
   parameter int          ADDR_W    = 2,
   parameter int unsigned STAT_ADDR = 1,
   parameter int unsigned DATA_ADDR = 2,
   parameter bit          REQ_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              rx_irq_en,
   input  logic              dma_sel,
   input  logic              rx_byte_done,
   input  logic              ovr_evt,
   input  logic              mfault_evt,
   input  logic              tx_load_evt,
   input  logic              tx_xfer_evt,
   output logic              rx_irq,
   output logic              rx_dma_req,
   output logic              err_irq
);
   import spi_stat_pkg::*;

   localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] DT_A = ADDR_W'(DATA_ADDR);

   generate
      if (ADDR_W < 1) begin : g_bad_w
         $error("ADDR_W must be at least 1");
      end
      if (STAT_ADDR == DATA_ADDR) begin : g_bad_map
         $error("status and data addresses must differ");
      end
      if (STAT_ADDR >= (1 << ADDR_W) || DATA_ADDR >= (1 << ADDR_W)) begin : g_bad_fit
         $error("address does not fit in ADDR_W");
      end
   endgenerate

   logic      sel_stat, sel_data;
   logic      stat_rd, stat_wr, data_rd;
   spi_stat_t stat;
   logic      unused_wbits;

   assign sel_stat     = (bus_addr == ST_A);
   assign sel_data     = (bus_addr == DT_A);
   assign stat_rd      = bus_rd && sel_stat;
   assign stat_wr      = bus_wr && sel_stat;
   assign data_rd      = bus_rd && sel_data;
   assign unused_wbits = ^{bus_wdata[7], bus_wdata[5:3]};

   spi_rx_flag #(.REQ_REG(REQ_REG)) u_rx (
      .clk(clk), .rst_n(rst_n), .byte_done(rx_byte_done),
      .stat_rd(stat_rd), .data_rd(data_rd), .dma_sel(dma_sel),
      .rx_ie(rx_irq_en), .rx_full(stat.rx_full),
      .rx_irq(rx_irq), .rx_dma_req(rx_dma_req)
   );

   spi_err_flags u_err (
      .clk(clk), .rst_n(rst_n), .ovr_evt(ovr_evt), .mf_evt(mfault_evt),
      .mf_en(stat.mf_en), .err_ie(stat.err_ie), .stat_rd(stat_rd),
      .data_rd(data_rd), .ovf(stat.ovf), .mfault(stat.mfault),
      .err_irq(err_irq)
   );

   spi_ctl_bits #(.RATE_W(RATE_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr_en(stat_wr),
      .wr_ie(bus_wdata[6]), .wr_mfen(bus_wdata[2]),
      .wr_rate(bus_wdata[RATE_W-1:0]),
      .tx_load(tx_load_evt), .tx_xfer(tx_xfer_evt),
      .err_ie(stat.err_ie), .mf_en(stat.mf_en),
      .rate(stat.rate), .tx_empty(stat.tx_empty)
   );

   assign bus_rdata = sel_stat ? stat : '0;

   assert_wr_ie_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> (bus_rdata[6] == $past(bus_wdata[6])) || !sel_stat);
   assert_wr_rxfull_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && !rx_byte_done && !stat.rx_full) |=> !stat.rx_full);
endmodule

// File: tb/spi_stat_ctl_tb.sv
module spi_stat_ctl_tb;
   localparam int ADDR_W = 2;
   localparam logic [1:0] STA = 2'd1;
   localparam logic [1:0] DTA = 2'd2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = STA;
   logic       bus_rd = 0, bus_wr = 0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       rx_irq_en = 0, dma_sel = 0;
   logic       rx_byte_done = 0, ovr_evt = 0, mfault_evt = 0;
   logic       tx_load_evt = 0, tx_xfer_evt = 0;
   logic       rx_irq, rx_dma_req, err_irq;

   int n_chk = 0, n_err = 0;

   // bench model
   bit m_full, m_armed, m_ovf, m_mf, m_earmed, m_eirq, m_ie, m_mfen, m_tx;
   bit [1:0] m_rate;

   always #4 clk = ~clk;

   spi_stat_ctl #(.ADDR_W(ADDR_W), .STAT_ADDR(1), .DATA_ADDR(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_irq_en(rx_irq_en), .dma_sel(dma_sel), .rx_byte_done(rx_byte_done),
      .ovr_evt(ovr_evt), .mfault_evt(mfault_evt), .tx_load_evt(tx_load_evt),
      .tx_xfer_evt(tx_xfer_evt), .rx_irq(rx_irq), .rx_dma_req(rx_dma_req),
      .err_irq(err_irq)
   );

   function automatic bit [7:0] exp_stat();
      return {m_full, m_ie, m_ovf, m_mf, m_tx, m_mfen, m_rate};
   endfunction

   task automatic check(input string what, input string req,
                        input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   task automatic model(input bit rd, wr, at_stat, input bit [7:0] wd,
                        input bit rxd, ovr, mfe, tld, txx);
      bit srd, drd, swr, clr, eclr, irq_n;
      srd = rd && at_stat; drd = rd && !at_stat; swr = wr && at_stat;
      clr  = drd && (dma_sel || m_armed);
      eclr = drd && m_earmed;
      irq_n = m_ie && (m_ovf || m_mf);
      if (srd && m_full) m_armed = 1; else if (clr) m_armed = 0;
      if (srd && (m_ovf || m_mf)) m_earmed = 1; else if (eclr) m_earmed = 0;
      m_full = rxd ? 1'b1 : (clr ? 1'b0 : m_full);
      m_ovf  = ovr ? 1'b1 : (eclr ? 1'b0 : m_ovf);
      m_mf   = (mfe && m_mfen) ? 1'b1 : (eclr ? 1'b0 : m_mf);
      m_eirq = irq_n;
      if (swr) begin m_ie = wd[6]; m_mfen = wd[2]; m_rate = wd[1:0]; end
      m_tx = tld ? 1'b0 : (txx ? 1'b1 : m_tx);
   endtask

   task automatic step(input bit rd, wr, at_stat, input bit [7:0] wd,
                       input bit rxd, ovr, mfe, tld, txx, input string tag);
      @(negedge clk);
      bus_rd = rd; bus_wr = wr; bus_addr = at_stat ? STA : DTA;
      bus_wdata = wd; rx_byte_done = rxd; ovr_evt = ovr; mfault_evt = mfe;
      tx_load_evt = tld; tx_xfer_evt = txx;
      @(posedge clk);
      model(rd, wr, at_stat, wd, rxd, ovr, mfe, tld, txx);
      #1;
      bus_rd = 0; bus_wr = 0; bus_addr = STA; rx_byte_done = 0;
      ovr_evt = 0; mfault_evt = 0; tx_load_evt = 0; tx_xfer_evt = 0;
      #1;
      check("status", tag, bus_rdata, exp_stat());
      check("rx_irq", "R4", {7'd0, rx_irq}, {7'd0, m_full && rx_irq_en && !dma_sel});
      check("rx_dma_req", "R4", {7'd0, rx_dma_req}, {7'd0, m_full && rx_irq_en && dma_sel});
      check("err_irq", "R9", {7'd0, err_irq}, {7'd0, m_eirq});
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin : stim
      int unsigned seed;
      seed = 32'd4177;
      void'($urandom(seed));
      m_tx = 1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      #1;
      // R1: reset state
      check("reset status", "R1", bus_rdata, 8'h08);
      check("reset irqs", "R1", {5'd0, rx_irq, rx_dma_req, err_irq}, 8'h00);
      // R2: non-status address reads zero
      bus_addr = DTA; #1;
      check("other addr", "R2", bus_rdata, 8'h00);
      bus_addr = STA;

      rx_irq_en = 1; dma_sel = 0;
      // R3: write of 1 to flag bits cannot set them
      step(0,1,1,8'hFF,0,0,0,0,0,"R3");
      // R8: only bits 6,2,1,0 written
      step(0,1,1,8'h00,0,0,0,0,0,"R8");
      step(0,1,1,8'h45,0,0,0,0,0,"R8");
      step(0,0,1,8'h00,1,0,0,0,0,"R3");
      // R5: data read without a prior status read keeps the flag
      step(1,0,0,8'h00,0,0,0,0,0,"R5");
      step(1,0,1,8'h00,0,0,0,0,0,"R5");
      step(1,0,0,8'h00,0,0,0,0,0,"R5");
      // R7: byte arrives during clearing read
      step(0,0,1,8'h00,1,0,0,0,0,"R7");
      step(1,0,1,8'h00,0,0,0,0,0,"R7");
      step(1,0,0,8'h00,1,0,0,0,0,"R7");
      // R6: DMA mode, any data read clears
      dma_sel = 1;
      step(1,0,0,8'h00,0,0,0,0,0,"R6");
      step(0,0,1,8'h00,1,0,0,0,0,"R6");
      step(1,0,0,8'h00,0,0,0,0,0,"R6");
      // R10: mode-fault gated by enable
      step(0,1,1,8'h40,0,0,0,0,0,"R10");
      step(0,0,1,8'h00,0,0,1,0,0,"R10");
      step(0,0,1,8'h00,0,1,0,0,0,"R10");
      step(0,1,1,8'h44,0,0,1,0,0,"R10");
      step(0,0,1,8'h00,0,0,1,0,0,"R10");
      // R11: clear pair, event during clear keeps its flag
      step(1,0,1,8'h00,0,0,0,0,0,"R11");
      step(1,0,0,8'h00,0,1,0,0,0,"R11");
      step(1,0,1,8'h00,0,0,0,0,0,"R11");
      step(1,0,0,8'h00,0,0,0,0,0,"R11");
      // R12: load wins over transfer
      step(0,0,1,8'h00,0,0,0,1,1,"R12");
      step(0,0,1,8'h00,0,0,0,0,1,"R12");
      step(0,0,1,8'h00,0,0,0,1,0,"R12");

      for (int i = 0; i < 3000; i++) begin
         int unsigned op;
         if (i % 40 == 0) begin
            rx_irq_en = 1'($urandom);
            dma_sel   = 1'($urandom);
         end
         op = $urandom % 10;
         step(op < 4, op == 4 || op == 5, (op < 2) || (op >= 4),
              8'($urandom),
              ($urandom % 7) == 0, ($urandom % 20) == 0,
              ($urandom % 20) == 0, ($urandom % 10) == 0,
              ($urandom % 10) == 0, "R2");
      end
      report();
   end
endmodule